// File: doc/BRIEF.md
# Strobed FIFO Buffer with Half-Full Status

This block is a first-in first-out buffer for 9-bit words. The write and read strobes are active-low and are sampled on the rising edge of one shared clock. Three status flags report empty, full and more than half full. Each flag is driven twice: once active-high, for logic nearby on the chip, and once as an active-low copy for a pin.

The depth is a parameter. It must be even and at least two, and an elaboration check rejects any other value. An active-low master reset clears both pointers, the occupancy and the status. When the clearing option is on, it also zeroes the storage. The read port is registered. A read the buffer can serve loads the oldest word into the output. A read it cannot serve loads the all-ones word. A write that finds the buffer full is dropped. A user that needs only a byte leaves bit 8 unused.

Top module: `strobe_fifo`

## Requirements
- R1: Words come out in the order they went in, with all nine bits intact. `dout` takes the word in the clock cycle in which the read strobe is sampled low.
- R2: While `rst_n` is low, and right after it, `empty` is 1, `full` and `half` are 0, and `dout` is all ones (0x1FF). Anything stored before the reset is gone.
- R3: A write strobe sampled while `full` is 1, with no read, leaves the stored words, the occupancy and every flag unchanged.
- R4: A read strobe sampled while `empty` is 1 puts 0x1FF on `dout` and does not move the read position.
- R5: `full` rises on the write that brings the occupancy to the depth. It falls on the next accepted read.
- R6: `empty` rises on the read that removes the last word. It falls on the next accepted write.
- R7: `half` rises on the write that brings the occupancy to depth/2 + 1. It falls on the read that brings the occupancy back to depth/2.
- R8: A read and a write in the same cycle, with the buffer neither empty nor full, are both accepted. The occupancy and the flags stay as they were.
- R9: A read and a write in the same cycle while empty: only the write is taken, and `dout` shows 0x1FF. The same pair while full: only the read is taken, and the written word is dropped.
- R10: `empty_n`, `full_n` and `half_n` are always the complements of `empty`, `full` and `half`.
- R11: Both positions wrap modulo the depth, so the order of words holds across any number of wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous master reset, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| din | input | WIDTH (9) | Word to store |
| dout | output | WIDTH (9) | Registered read word, all ones when the read finds nothing |
| empty | output | 1 | High when no word is held |
| full | output | 1 | High when depth words are held |
| half | output | 1 | High when more than depth/2 words are held |
| empty_n | output | 1 | Active-low copy of empty |
| full_n | output | 1 | Active-low copy of full |
| half_n | output | 1 | Active-low copy of half |

## Verification
The bench checks `half` at depth/2 and at depth/2 + 1, going up and going down. A threshold that is off by one moves the edge of `half` by one operation, and the reference queue catches that. It writes while full and then drains the whole buffer. A design that let the extra write in would overwrite the oldest word or hand back a stray value. It pairs reads with writes when empty, when full and in between. A wrong acceptance rule would return a stale word instead of 0x1FF, or would lose the dropped word's place in the order. A run of mixed operations carries both positions through several wraps, and a reset in the middle of a run must bring back the empty state and the all-ones output.

// File: rtl/fifo9_pkg.sv
package fifo9_pkg;

   localparam int unsigned WORD_W = 9;

   typedef enum logic [1:0] {
      OP_IDLE = 2'b00,
      OP_RD   = 2'b01,
      OP_WR   = 2'b10,
      OP_BOTH = 2'b11
   } access_e;

   typedef struct packed {
      logic empty;
      logic full;
      logic half;
   } flags_t;

endpackage

// File: rtl/fifo9_ptr.sv
module fifo9_ptr #(
   parameter int unsigned DEPTH = 1024,
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic [AW-1:0] ptr
);

   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   generate
      if (POW2) begin : g_pow2
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   ptr <= '0;
            else if (adv) ptr <= ptr + 1'b1;
         end
      end else begin : g_mod
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   ptr <= '0;
            else if (adv) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/fifo9_store.sv
module fifo9_store #(
   parameter int unsigned WIDTH = 9,
   parameter int unsigned DEPTH = 1024,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] mem [DEPTH];

   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we) begin
               mem[waddr] <= wdata;
            end
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (we) mem[waddr] <= wdata;
         end
      end
   endgenerate

   assign rdata = mem[raddr];

endmodule

// File: rtl/fifo9_flags.sv
module fifo9_flags
   import fifo9_pkg::*;
#(
   parameter int unsigned DEPTH = 1024,
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_req,
   input  logic          rd_req,
   output logic          wr_acc,
   output logic          rd_acc,
   output logic [CW-1:0] occ,
   output flags_t        flags
);

   localparam logic [CW-1:0] FULL_OCC = CW'(DEPTH);
   localparam logic [CW-1:0] HALF_OCC = CW'(DEPTH / 2);

   access_e       op;
   logic [CW-1:0] occ_next;

   always_comb begin
      rd_acc = rd_req && !flags.empty;
      wr_acc = wr_req && !flags.full;
      op     = access_e'({wr_acc, rd_acc});
      unique case (op)
         OP_WR:   occ_next = occ + 1'b1;
         OP_RD:   occ_next = occ - 1'b1;
         default: occ_next = occ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ   <= '0;
         flags <= '{empty: 1'b1, full: 1'b0, half: 1'b0};
      end else if (op == OP_WR || op == OP_RD) begin
         occ         <= occ_next;
         flags.empty <= (occ_next == '0);
         flags.full  <= (occ_next == FULL_OCC);
         flags.half  <= (occ_next > HALF_OCC);
      end
   end

endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
   import fifo9_pkg::*;
#(
   parameter int unsigned WIDTH = WORD_W,
   parameter int unsigned DEPTH = 1024,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_n,
   input  logic             rd_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic             empty,
   output logic             full,
   output logic             half,
   output logic             empty_n,
   output logic             full_n,
   output logic             half_n
);

   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (DEPTH % 2) != 0) begin : g_bad_depth
         $error("strobe_fifo: DEPTH must be even and at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("strobe_fifo: WIDTH must be at least 1");
      end
   endgenerate

   logic             wr_req, rd_req, wr_acc, rd_acc;
   logic [AW-1:0]    wptr, rptr;
   logic [CW-1:0]    occ;
   logic [WIDTH-1:0] rdata;
   flags_t           flags;

   assign wr_req = !wr_n;
   assign rd_req = !rd_n;

   fifo9_flags #(.DEPTH(DEPTH)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_req (wr_req),
      .rd_req (rd_req),
      .wr_acc (wr_acc),
      .rd_acc (rd_acc),
      .occ    (occ),
      .flags  (flags)
   );

   fifo9_ptr #(.DEPTH(DEPTH)) u_wptr (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (wr_acc),
      .ptr   (wptr)
   );

   fifo9_ptr #(.DEPTH(DEPTH)) u_rptr (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (rd_acc),
      .ptr   (rptr)
   );

   fifo9_store #(
      .WIDTH          (WIDTH),
      .DEPTH          (DEPTH),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_acc),
      .waddr (wptr),
      .wdata (din),
      .raddr (rptr),
      .rdata (rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dout <= '1;
      else if (rd_req) dout <= rd_acc ? rdata : '1;
   end

   assign empty   = flags.empty;
   assign full    = flags.full;
   assign half    = flags.half;
   assign empty_n = ~flags.empty;
   assign full_n  = ~flags.full;
   assign half_n  = ~flags.half;

endmodule

// File: rtl/fifo9_chk.sv
module fifo9_chk #(
   parameter int unsigned WIDTH = 9,
   parameter int unsigned DEPTH = 1024,
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_n,
   input logic             rd_n,
   input logic [WIDTH-1:0] dout,
   input logic             empty,
   input logic             full,
   input logic             half,
   input logic [CW-1:0]    occ
);

   localparam logic [CW-1:0] HALF_OCC = CW'(DEPTH / 2);
   localparam logic [CW-1:0] OVER_OCC = CW'(DEPTH / 2 + 1);

   AST_RESET_STATE: assert property (@(posedge clk)
      !rst_n |=> (empty && !full && !half && dout == '1)); // R2

   AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !wr_n && rd_n) |=> (full && occ == $past(occ))); // R3

   AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && !rd_n) |=> (dout == '1)); // R4

   AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      !(empty && full)); // R5

   AST_HALF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == HALF_OCC && !wr_n && rd_n) |=> half); // R7

   AST_HALF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == OVER_OCC && !rd_n && wr_n) |=> !half); // R7

   AST_PAIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty && !full && !wr_n && !rd_n) |=> (occ == $past(occ))); // R8

endmodule

bind strobe_fifo fifo9_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .wr_n  (wr_n),
   .rd_n  (rd_n),
   .dout  (dout),
   .empty (empty),
   .full  (full),
   .half  (half),
   .occ   (occ)
);

// File: tb/test_strobe_fifo.sv
module test_strobe_fifo;

   localparam int unsigned DEPTH = 8;
   localparam int unsigned W = 9;
   localparam int NVEC = 32;
   localparam logic [W-1:0] ONES = '1;

   // {write, read, data}
   localparam logic [W+1:0] VEC [NVEC] = '{
      {2'b10, 9'h101}, {2'b10, 9'h0F2}, {2'b10, 9'h1E3}, {2'b01, 9'h000},
      {2'b11, 9'h054}, {2'b10, 9'h165}, {2'b10, 9'h076}, {2'b10, 9'h187},
      {2'b10, 9'h098}, {2'b11, 9'h1A9}, {2'b01, 9'h000}, {2'b01, 9'h000},
      {2'b10, 9'h0BA}, {2'b10, 9'h1CB}, {2'b10, 9'h0DC}, {2'b10, 9'h1ED},
      {2'b01, 9'h000}, {2'b01, 9'h000}, {2'b11, 9'h0FE}, {2'b01, 9'h000},
      {2'b01, 9'h000}, {2'b01, 9'h000}, {2'b01, 9'h000}, {2'b01, 9'h000},
      {2'b01, 9'h000}, {2'b01, 9'h000}, {2'b01, 9'h000}, {2'b10, 9'h10F},
      {2'b11, 9'h020}, {2'b11, 9'h131}, {2'b01, 9'h000}, {2'b01, 9'h000}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_n = 1'b1;
   logic rd_n = 1'b1;
   logic [W-1:0] din = '0;
   logic [W-1:0] dout;
   logic empty, full, half, empty_n, full_n, half_n;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   logic [W-1:0] model [$];
   logic [W-1:0] exp_dout = ONES;

   always #2 clk = ~clk;

   strobe_fifo #(.DEPTH(DEPTH)) i_strobe_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_n    (wr_n),
      .rd_n    (rd_n),
      .din     (din),
      .dout    (dout),
      .empty   (empty),
      .full    (full),
      .half    (half),
      .empty_n (empty_n),
      .full_n  (full_n),
      .half_n  (half_n)
   );

   task automatic cmp(string req, string ctx, string what, logic [31:0] act, logic [31:0] exp);
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s (%s) %s actual=%0h expected=%0h", req, ctx, what, act, exp);
      end
   endtask

   task automatic check_all(string dreq, string ctx);
      int sz;
      sz = model.size();
      vectors++;
      cmp(dreq, ctx, "dout", 32'(dout), 32'(exp_dout));
      cmp("R6", ctx, "empty", 32'(empty), 32'(sz == 0));
      cmp("R5", ctx, "full", 32'(full), 32'(sz == DEPTH));
      cmp("R7", ctx, "half", 32'(half), 32'(sz > DEPTH / 2));
      cmp("R10", ctx, "empty_n", 32'(empty_n), 32'(sz != 0));
      cmp("R10", ctx, "full_n", 32'(full_n), 32'(sz != DEPTH));
      cmp("R10", ctx, "half_n", 32'(half_n), 32'(sz <= DEPTH / 2));
   endtask

   // Called at a falling edge; returns at the next falling edge after checking.
   task automatic op(bit w, bit r, logic [W-1:0] d, string ctx);
      int sz;
      string dreq;
      sz = model.size();
      dreq = (r && sz == 0) ? "R4" : "R1";
      wr_n = !w;
      rd_n = !r;
      din  = d;
      @(posedge clk);
      if (r) begin
         if (sz > 0) exp_dout = model.pop_front();
         else        exp_dout = ONES;
      end
      if (w && sz < DEPTH) model.push_back(d);
      @(negedge clk);
      wr_n = 1'b1;
      rd_n = 1'b1;
      check_all(dreq, ctx);
   endtask

   task automatic do_reset(string ctx);
      rst_n = 1'b0;
      model.delete();
      exp_dout = ONES;
      @(negedge clk);
      check_all("R2", ctx);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R2", ctx);
   endtask

   initial begin
      @(negedge clk);
      // R2: state out of the first reset
      do_reset("R2 initial reset");

      // R4: reads on an empty buffer
      op(1'b0, 1'b1, '0, "R4 empty read");
      op(1'b0, 1'b1, '0, "R4 empty read again");

      // R7 / R5: fill one word at a time; half rises at 5 of 8, full at 8
      for (int i = 0; i < DEPTH; i++) op(1'b1, 1'b0, W'(9'h100 + i), "R7 R5 fill");

      // R3: extra write while full is dropped
      op(1'b1, 1'b0, 9'h0AA, "R3 write while full");
      // R9: pair while full -> read only
      op(1'b1, 1'b1, 9'h155, "R9 pair while full");
      op(1'b1, 1'b0, 9'h1C3, "R5 refill");

      // R3 / R7 / R6: drain everything; half falls at 4, empty at 0
      for (int i = 0; i < DEPTH; i++) op(1'b0, 1'b1, '0, "R3 R7 R6 drain");
      op(1'b0, 1'b1, '0, "R4 read after drain");

      // R9: pair while empty -> write only, dout all ones
      op(1'b1, 1'b1, 9'h0F0, "R9 pair while empty");
      op(1'b1, 1'b0, 9'h0F1, "R8 setup");
      op(1'b1, 1'b0, 9'h0F2, "R8 setup");
      // R8: pairs in the middle keep occupancy and flags
      op(1'b1, 1'b1, 9'h0F3, "R8 pair");
      op(1'b1, 1'b1, 9'h0F4, "R8 pair");
      // R7: pairs at the half threshold
      op(1'b1, 1'b0, 9'h0F5, "R7 to half");
      op(1'b1, 1'b1, 9'h0F6, "R8 R7 pair at half");
      op(1'b1, 1'b0, 9'h0F7, "R7 over half");
      op(1'b1, 1'b1, 9'h0F8, "R8 R7 pair over half");
      op(1'b0, 1'b1, '0, "R7 back to half");

      // R1 / R11: stimulus table with wraps
      for (int i = 0; i < NVEC; i++)
         op(VEC[i][W+1], VEC[i][W], VEC[i][W-1:0], "R1 R11 table");
      while (model.size() > 0) op(1'b0, 1'b1, '0, "R11 final drain");

      // R2: reset in the middle of a run clears the contents
      for (int i = 0; i < 6; i++) op(1'b1, 1'b0, W'(9'h1F0 + i), "R2 preload");
      do_reset("R2 reset with data");
      op(1'b0, 1'b1, '0, "R2 read after reset");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         miscompares++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule